// File: doc/BRIEF.md
# Protection Flag Filter and Fault Latch

This block sits between the analog protection comparators of a stepper motor power stage and its output control. It takes three raw comparator levels (over-current, over-temperature shutdown and an early thermal warning), rejects short glitches on each with its own run-length filter, and turns the survivors into control signals. A confirmed over-current or shutdown event is held. While it is held, the power transistors are forced off and the error indicator pull-down is switched on. The thermal warning is not held: its indicator follows the filtered condition and releases on its own.

The filters count cycles of the internal system oscillator, nominally 6.4 MHz. The lengths are 8 cycles for over-current, 32 for shutdown and 16 for the warning. A held fault is cleared only by the active-low standby input or by the power-on reset. While standby is low, the whole block is frozen in its cleared state and the outputs are forced off. When standby is released, a wake-up flag stays low for 64 cycles before the surrounding logic may accept commands again.

Top module: `fault_guard`

## Requirements
- R1: With standby high, `err_pull` and `out_off` become 1 after the clock edge at which `ocp_raw` has been sampled high at 8 consecutive edges. After only 7 such edges, both stay 0.
- R2: `tsd_raw` sets the same held fault, but only once it has been sampled high at 32 consecutive edges. After 31 edges there is no fault.
- R3: `alm_pull` becomes 1 after `alm_raw` has been sampled high at 16 consecutive edges. After 15 edges it stays 0.
- R4: A single low sample on a raw flag before its count completes restarts that flag's count from zero.
- R5: Once set, `err_pull` (1 = error pin pulled low) and `out_off` (1 = all power transistors off) stay 1 after the raw flag falls, for as long as standby stays high.
- R6: `alm_pull` returns to 0 at the first edge at which `alm_raw` is sampled low. The warning never sets `err_pull` or `out_off`.
- R7: While `stby_n` is 0, `out_off` is 1 at once. At the next edge the held faults, the warning and the wake-up flag are cleared, and raw flags are ignored for as long as standby stays low.
- R8: After `stby_n` rises, `wake_ok` stays 0 until `stby_n` has been sampled high at 64 edges, and is 1 after that edge.
- R9: `por_n` low clears the held faults, the warning, the filter counts and the wake-up flag asynchronously.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal system oscillator clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| stby_n | input | 1 | Standby control, 0 = low-power state |
| ocp_raw | input | 1 | Raw over-current comparator level |
| tsd_raw | input | 1 | Raw over-temperature shutdown comparator level |
| alm_raw | input | 1 | Raw thermal warning level, hysteresis already applied |
| out_off | output | 1 | 1 = all output transistors forced off |
| err_pull | output | 1 | 1 = error pin open-drain transistor on |
| alm_pull | output | 1 | 1 = warning pin open-drain transistor on |
| wake_ok | output | 1 | 1 = wake-up delay after standby has elapsed |

## Verification
The checker watches several properties on every cycle. The error indication never rises unless one raw flag has a run as long as its filter. The warning and wake-up flags never rise early. A held error survives for as long as standby stays high. Standby clears everything, and the warning drops one edge after its raw level falls. Exact edge placement is shown only by the bench: off-by-one filter lengths, a count restarted by a one-cycle gap, raw flags ignored during standby, and the asynchronous reset clearing a held fault.

// File: rtl/fault_guard.sv
module fault_guard #(
  parameter int OCP_MASK = 8,
  parameter int TSD_MASK = 32,
  parameter int ALM_MASK = 16,
  parameter int WAKE_CYC = 64
) (
  input  logic clk,
  input  logic por_n,
  input  logic stby_n,
  input  logic ocp_raw,
  input  logic tsd_raw,
  input  logic alm_raw,
  output logic out_off,
  output logic err_pull,
  output logic alm_pull,
  output logic wake_ok
);
  localparam int LEN [3] = '{OCP_MASK, TSD_MASK, ALM_MASK};
  localparam int ML1 = (OCP_MASK > TSD_MASK) ? OCP_MASK : TSD_MASK;
  localparam int MLEN = (ML1 > ALM_MASK) ? ML1 : ALM_MASK;
  localparam int CW = $clog2(MLEN + 1);
  localparam int WW = $clog2(WAKE_CYC + 1);

  logic [2:0] raw, hit;
  logic ocp_lat, tsd_lat, alm_q;
  logic [WW-1:0] wcnt;

  assign raw = {alm_raw, tsd_raw, ocp_raw};

  for (genvar i = 0; i < 3; i++) begin : g_mask
    logic [CW-1:0] cnt;
    assign hit[i] = stby_n && raw[i] && (cnt == CW'(LEN[i] - 1));
    always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)                  cnt <= '0;
      else if (!stby_n || !raw[i]) cnt <= '0;
      else if (!hit[i])            cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      ocp_lat <= 1'b0;
      tsd_lat <= 1'b0;
      alm_q   <= 1'b0;
      wcnt    <= '0;
    end else if (!stby_n) begin
      ocp_lat <= 1'b0;
      tsd_lat <= 1'b0;
      alm_q   <= 1'b0;
      wcnt    <= '0;
    end else begin
      ocp_lat <= ocp_lat | hit[0];
      tsd_lat <= tsd_lat | hit[1];
      alm_q   <= hit[2];
      if (wcnt != WW'(WAKE_CYC)) wcnt <= wcnt + 1'b1;
    end
  end

  assign err_pull = ocp_lat | tsd_lat;
  assign out_off  = !stby_n | ocp_lat | tsd_lat;
  assign alm_pull = alm_q;
  assign wake_ok  = (wcnt == WW'(WAKE_CYC));
endmodule

// File: rtl/fault_guard_chk.sv
module fault_guard_chk #(
  parameter int OCP_MASK = 8,
  parameter int TSD_MASK = 32,
  parameter int ALM_MASK = 16,
  parameter int WAKE_CYC = 64
) (
  input logic clk,
  input logic por_n,
  input logic stby_n,
  input logic ocp_raw,
  input logic tsd_raw,
  input logic alm_raw,
  input logic out_off,
  input logic err_pull,
  input logic alm_pull,
  input logic wake_ok
);
  logic [15:0] run_o, run_t, run_a, run_s;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      run_o <= '0; run_t <= '0; run_a <= '0; run_s <= '0;
    end else begin
      run_o <= (!stby_n || !ocp_raw) ? 16'd0 : (run_o == 16'hFFFF ? run_o : run_o + 16'd1);
      run_t <= (!stby_n || !tsd_raw) ? 16'd0 : (run_t == 16'hFFFF ? run_t : run_t + 16'd1);
      run_a <= (!stby_n || !alm_raw) ? 16'd0 : (run_a == 16'hFFFF ? run_a : run_a + 16'd1);
      run_s <= (!stby_n) ? 16'd0 : (run_s == 16'hFFFF ? run_s : run_s + 16'd1);
    end
  end

  AST_ERR_NEEDS_RUN: assert property (@(posedge clk) disable iff (!por_n)
    $rose(err_pull) |-> (run_o >= 16'(OCP_MASK)) || (run_t >= 16'(TSD_MASK))); // R1 R2
  AST_ALM_NEEDS_RUN: assert property (@(posedge clk) disable iff (!por_n)
    $rose(alm_pull) |-> run_a >= 16'(ALM_MASK)); // R3
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!por_n)
    (err_pull && stby_n) |=> err_pull); // R5
  AST_ERR_FORCES_OFF: assert property (@(posedge clk) disable iff (!por_n)
    err_pull |-> out_off); // R5
  AST_ALM_RELEASE: assert property (@(posedge clk) disable iff (!por_n)
    !alm_raw |=> !alm_pull); // R6
  AST_STBY_CLEARS: assert property (@(posedge clk) disable iff (!por_n)
    !stby_n |=> (!err_pull && !alm_pull && !wake_ok)); // R7
  AST_STBY_OFF: assert property (@(posedge clk) disable iff (!por_n)
    !stby_n |-> out_off); // R7
  AST_WAKE_DELAY: assert property (@(posedge clk) disable iff (!por_n)
    $rose(wake_ok) |-> run_s >= 16'(WAKE_CYC)); // R8
endmodule

bind fault_guard fault_guard_chk #(
  .OCP_MASK(OCP_MASK), .TSD_MASK(TSD_MASK), .ALM_MASK(ALM_MASK), .WAKE_CYC(WAKE_CYC)
) u_chk (
  .clk(clk), .por_n(por_n), .stby_n(stby_n), .ocp_raw(ocp_raw), .tsd_raw(tsd_raw),
  .alm_raw(alm_raw), .out_off(out_off), .err_pull(err_pull), .alm_pull(alm_pull),
  .wake_ok(wake_ok)
);

// File: tb/sim_fault_guard.sv
module sim_fault_guard;
  localparam int PERIOD = 10;
  localparam int NV = 8;
  // flag (0 ocp, 1 tsd, 2 alm), cycles high, expected err, expected alarm
  localparam int VEC [NV][4] = '{
    '{0, 7, 0, 0}, '{0, 8, 1, 0}, '{1, 31, 0, 0}, '{1, 32, 1, 0},
    '{2, 15, 0, 0}, '{2, 16, 0, 1}, '{0, 20, 1, 0}, '{2, 40, 0, 1}
  };

  logic clk = 1'b0, por_n = 1'b0, stby_n = 1'b1;
  logic ocp_raw = 1'b0, tsd_raw = 1'b0, alm_raw = 1'b0;
  logic out_off, err_pull, alm_pull, wake_ok;
  int checks = 0, errors = 0;

  fault_guard u0 (
    .clk(clk), .por_n(por_n), .stby_n(stby_n), .ocp_raw(ocp_raw), .tsd_raw(tsd_raw),
    .alm_raw(alm_raw), .out_off(out_off), .err_pull(err_pull), .alm_pull(alm_pull),
    .wake_ok(wake_ok)
  );

  always #(PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_raw(input int f, input logic v);
    if (f == 0) ocp_raw = v;
    else if (f == 1) tsd_raw = v;
    else alm_raw = v;
  endtask

  task automatic stby_pulse();
    stby_n = 1'b0;
    hold(1);
    stby_n = 1'b1;
  endtask

  initial begin
    #(PERIOD * 100000);
    errors++;
    $display("FAIL watchdog all-reqs actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    hold(2);
    chk("R9 reset err_pull", err_pull, 1'b0);
    chk("R9 reset alm_pull", alm_pull, 1'b0);
    chk("R9 reset wake_ok", wake_ok, 1'b0);
    chk("R9 reset out_off", out_off, 1'b0);
    por_n = 1'b1;
    hold(1);

    for (int v = 0; v < NV; v++) begin
      stby_pulse();
      set_raw(VEC[v][0], 1'b1);
      hold(VEC[v][1]);
      chk($sformatf("R1 R2 R3 vec%0d err_pull", v), err_pull, VEC[v][2] != 0);
      chk($sformatf("R3 vec%0d alm_pull", v), alm_pull, VEC[v][3] != 0);
      chk($sformatf("R6 vec%0d out_off", v), out_off, VEC[v][2] != 0);
      set_raw(VEC[v][0], 1'b0);
      hold(1);
      chk($sformatf("R6 vec%0d alarm released", v), alm_pull, 1'b0);
      chk($sformatf("R5 vec%0d err held", v), err_pull, VEC[v][2] != 0);
      chk($sformatf("R5 vec%0d out_off held", v), out_off, VEC[v][2] != 0);
    end

    // R4: gap of one cycle restarts the count
    stby_pulse();
    ocp_raw = 1'b1; hold(7);
    ocp_raw = 1'b0; hold(1);
    ocp_raw = 1'b1; hold(7);
    chk("R4 no fault after gap", err_pull, 1'b0);
    hold(1);
    chk("R4 fault after full run", err_pull, 1'b1);
    ocp_raw = 1'b0;

    // R7: standby clears and ignores raw flags
    hold(3);
    chk("R5 still latched", err_pull, 1'b1);
    stby_n = 1'b0;
    #1;
    chk("R7 out_off immediate", out_off, 1'b1);
    ocp_raw = 1'b1; tsd_raw = 1'b1; alm_raw = 1'b1;
    hold(40);
    chk("R7 err cleared in standby", err_pull, 1'b0);
    chk("R7 alm ignored in standby", alm_pull, 1'b0);
    chk("R7 out_off in standby", out_off, 1'b1);
    chk("R7 wake low in standby", wake_ok, 1'b0);
    ocp_raw = 1'b0; tsd_raw = 1'b0; alm_raw = 1'b0;

    // R8: wake-up delay
    stby_n = 1'b1;
    hold(63);
    chk("R8 wake low at 63", wake_ok, 1'b0);
    hold(1);
    chk("R8 wake high at 64", wake_ok, 1'b1);
    chk("R7 out_off released", out_off, 1'b0);

    // R9: asynchronous reset clears a held fault
    tsd_raw = 1'b1; hold(32); tsd_raw = 1'b0;
    chk("R2 tsd latched", err_pull, 1'b1);
    #1 por_n = 1'b0;
    #1;
    chk("R9 async err clear", err_pull, 1'b0);
    chk("R9 async out_off clear", out_off, 1'b0);
    chk("R9 async wake clear", wake_ok, 1'b0);
    hold(1);
    por_n = 1'b1;
    hold(2);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule